// File: doc/BRIEF.md
# Set-Reset Dual-Compare PWM Timer

This block is a 16-bit up-counting timer that drives two pulse-width-modulated outputs, `pwm_a` and `pwm_b`. Each output has a pair of compare values. A match with the first value of the pair (the "rise" value) drives the output high. A match with the second value (the "fall" value) drives it low. The two edges of each pulse can therefore be placed anywhere within the period, independently of each other. The fall value of output A also sets the period: the counter wraps to zero on the tick after it equals that value. Optionally, a shadow register reloads the A fall value at each wrap, so that software can change the period without a glitch.

The counter only moves on clock cycles where the `tick` input is high. Compares are evaluated on those ticks alone. Software controls the block through a small synchronous write port and a combinational read port. Through this port it programs the compare values, starts and stops the count, and observes and clears two sticky match flags.

Sequencing is held in a three-state machine:
- `ST_IDLE` is the state after reset, with the counter at zero and both outputs low.
- `ST_RUN` is the counting state.
- `ST_HOLD` is the state after a stop: the counter and both outputs are frozen.

The transitions are:
- `IDLE→RUN` when the run bit is set.
- `RUN→HOLD` when the run bit is cleared.
- `HOLD→RUN` when the run bit is set again, in which case counting resumes from the frozen value.

Every other case keeps the current state. The state machine follows the run bit one clock after it is written.

Top module: `pwm_setclr_timer`

## Requirements
- R1: After reset the count is 0, both outputs are low, and every register reads 0.
- R2: While running, the count rises by exactly one on each clock with `tick` high and does not change on clocks with `tick` low.
- R3: On a tick where the count equals the A fall value m, the count becomes 0, giving a period of m+1 ticks.
- R4: `pwm_a` goes high on the tick where the count equals the A rise value n and low on the tick where it equals m, so it is high m−n ticks per period when n<m and never high when n>m.
- R5: `pwm_b` goes high on the tick where the count equals the B rise value q and low on the tick where it equals the B fall value p; in steady state it is high (p−q) mod (m+1) ticks per period when both values are at most m.
- R6: When an output's rise and fall values are equal, the fall action wins and that output stays low.
- R7: Clearing the run bit freezes the count and both outputs; setting it again resumes counting from the frozen count.
- R8: Flag A (bit 0 of address 1) is set on a tick matching m, and flag B (bit 1) on a tick matching p; writing 0 to a flag bit clears it, and writing 1 leaves it unchanged.
- R9: If a match and a software clear of the same flag happen in the same clock, the flag ends up set.
- R10: With the buffer-enable bit (control bit 1) set, the A fall value is loaded from the shadow register (address 4) on every tick matching m, so a new shadow value first changes the period after the current period ends.
- R11: Register map: 0 control (bit 0 run, bit 1 buffer enable), 1 flags, 2 A rise, 3 A fall, 4 A fall shadow, 5 B rise, 6 B fall, 7 count (read only); written values read back at their address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, high for one clock per count step |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The bench aims at these corner cases:
- A B pulse that wraps across the period boundary. A design that compares only within one pass would lose that pulse.
- Equal rise and fall values. If priority were given to the rise, a stuck-high output would result.
- A rise value beyond the period. A wrong compare would glitch the output high.
- A shadow update in the middle of a period. An early reload would cut the current period short.
- A flag cleared by software in the very cycle it is set. The match must win; otherwise the event would be lost.
- Stop and resume with both outputs live. A design that resets instead of freezing would restart the pulse.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } tmr_state_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd1;
    localparam logic [ADDR_W-1:0] A_RISEA = 3'd2;
    localparam logic [ADDR_W-1:0] A_FALLA = 3'd3;
    localparam logic [ADDR_W-1:0] A_SHADW = 3'd4;
    localparam logic [ADDR_W-1:0] A_RISEB = 3'd5;
    localparam logic [ADDR_W-1:0] A_FALLB = 3'd6;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd7;

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              hit_a,
    input  logic              hit_b,
    input  logic [CNT_W-1:0]  cnt,
    output logic              run,
    output logic              buf_en,
    output logic [CNT_W-1:0]  rise_a,
    output logic [CNT_W-1:0]  fall_a,
    output logic [CNT_W-1:0]  rise_b,
    output logic [CNT_W-1:0]  fall_b
);

    localparam int NFLAG = 2;

    logic [CNT_W-1:0] shadow_q;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] hit_vec;
    logic             reload;
    logic             unused_wbits;

    assign hit_vec      = {hit_b, hit_a};
    assign reload       = hit_a && buf_en;
    assign unused_wbits = ^reg_wdata[CNT_W-1:NFLAG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run      <= 1'b0;
            buf_en   <= 1'b0;
            rise_a   <= '0;
            fall_a   <= '0;
            shadow_q <= '0;
            rise_b   <= '0;
            fall_b   <= '0;
        end else begin
            if (reg_we) begin
                unique case (reg_addr)
                    A_CTRL:  begin
                        run    <= reg_wdata[0];
                        buf_en <= reg_wdata[1];
                    end
                    A_RISEA: rise_a   <= reg_wdata;
                    A_SHADW: shadow_q <= reg_wdata;
                    A_RISEB: rise_b   <= reg_wdata;
                    A_FALLB: fall_b   <= reg_wdata;
                    default: ;
                endcase
            end
            if (reload) begin
                fall_a <= shadow_q;
            end else if (reg_we && reg_addr == A_FALLA) begin
                fall_a <= reg_wdata;
            end
        end
    end

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[gi] <= 1'b0;
            end else if (hit_vec[gi]) begin
                flag_q[gi] <= 1'b1;
            end else if (reg_we && reg_addr == A_FLAGS && !reg_wdata[gi]) begin
                flag_q[gi] <= 1'b0;
            end
        end

        p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[gi] |=> flag_q[gi]);
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:  reg_rdata[1:0] = {buf_en, run};
            A_FLAGS: reg_rdata[NFLAG-1:0] = flag_q;
            A_RISEA: reg_rdata = rise_a;
            A_FALLA: reg_rdata = fall_a;
            A_SHADW: reg_rdata = shadow_q;
            A_RISEB: reg_rdata = rise_b;
            A_FALLB: reg_rdata = fall_b;
            A_COUNT: reg_rdata = cnt;
            default: reg_rdata = '0;
        endcase
    end

    p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && buf_en) |=> fall_a == $past(shadow_q));

    p_flag_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !(reg_we && reg_addr == A_FLAGS)) |=> flag_q[0]);

endmodule

// File: rtl/pwm_tmr_cnt.sv
module pwm_tmr_cnt
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             wrap,
    output logic             step,
    output logic [CNT_W-1:0] cnt
);

    tmr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run)  state_d = ST_RUN;
            ST_RUN:  if (!run) state_d = ST_HOLD;
            ST_HOLD: if (run)  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        step = (state_q == ST_RUN) && tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (step) begin
            if (wrap) cnt <= '0;
            else      cnt <= cnt + 1'b1;
        end
    end

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wrap) |=> cnt == $past(cnt) + 1'b1);

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wrap) |=> cnt == '0);

    p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> $stable(cnt));

endmodule

// File: rtl/pwm_tmr_chan.sv
module pwm_tmr_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] rise_val,
    input  logic [CNT_W-1:0] fall_val,
    output logic             fall_hit,
    output logic             out_q
);

    logic rise_hit;

    assign rise_hit = step && (cnt == rise_val);
    assign fall_hit = step && (cnt == fall_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_q <= 1'b0;
        else if (fall_hit) out_q <= 1'b0;
        else if (rise_hit) out_q <= 1'b1;
    end

    p_fall_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == fall_val) |=> !out_q);

    p_rise_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == rise_val && cnt != fall_val) |=> out_q);

    p_out_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(out_q));

endmodule

// File: rtl/pwm_setclr_timer.sv
module pwm_setclr_timer
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              pwm_a,
    output logic              pwm_b
);

    localparam int NCH = 2;

    logic             run, buf_en, step;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rise_v [NCH];
    logic [CNT_W-1:0] fall_v [NCH];
    logic [NCH-1:0]   hit_v;
    logic [NCH-1:0]   out_v;

    pwm_tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hit_a     (hit_v[0]),
        .hit_b     (hit_v[1]),
        .cnt       (cnt),
        .run       (run),
        .buf_en    (buf_en),
        .rise_a    (rise_v[0]),
        .fall_a    (fall_v[0]),
        .rise_b    (rise_v[1]),
        .fall_b    (fall_v[1])
    );

    pwm_tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .wrap  (hit_v[0]),
        .step  (step),
        .cnt   (cnt)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        pwm_tmr_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (step),
            .cnt      (cnt),
            .rise_val (rise_v[ch]),
            .fall_val (fall_v[ch]),
            .fall_hit (hit_v[ch]),
            .out_q    (out_v[ch])
        );
    end

    assign pwm_a = out_v[0];
    assign pwm_b = out_v[1];

    p_period_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == fall_v[0]) |=> (cnt == '0 && !pwm_a));

endmodule

// File: tb/test_pwm_setclr_timer.sv
`timescale 1ns/1ps
module test_pwm_setclr_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        pwm_a, pwm_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_setclr_timer i_pwm_setclr_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    // columns: n, m, q, p, A high per period, B high per period
    localparam int NV = 5;
    localparam int VEC [0:NV-1][0:5] = '{
        '{ 2,  9,  4, 7,  7, 3},
        '{ 0,  5,  1, 5,  5, 4},
        '{ 3,  3,  2, 2,  0, 0},
        '{10, 20, 15, 3, 10, 9},
        '{ 5,  4,  1, 2,  0, 1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #0.5;
        v = int'(reg_rdata);
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); tick = 1'b1;
        end
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; tick = 1'b0; reg_we = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int v, ha, hb, zc, c0, pa0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(pwm_a == 0 && pwm_b == 0, "R1 outputs", int'({pwm_a, pwm_b}), 0);
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            chk(v == 0, "R1 register", v, 0);
        end

        // R11 readback
        wr(3'd2, 16'h1234); wr(3'd3, 16'hBEEF); wr(3'd4, 16'h0F0F);
        wr(3'd5, 16'h00AA); wr(3'd6, 16'h5500); wr(3'd0, 16'h0002);
        rd(3'd2, v); chk(v == 16'h1234, "R11 A rise", v, 16'h1234);
        rd(3'd3, v); chk(v == 16'hBEEF, "R11 A fall", v, 16'hBEEF);
        rd(3'd4, v); chk(v == 16'h0F0F, "R11 shadow", v, 16'h0F0F);
        rd(3'd5, v); chk(v == 16'h00AA, "R11 B rise", v, 16'h00AA);
        rd(3'd6, v); chk(v == 16'h5500, "R11 B fall", v, 16'h5500);
        rd(3'd0, v); chk(v == 2, "R11 control", v, 2);

        // vector table: R4 R5 R6 R3
        for (int k = 0; k < NV; k++) begin
            do_reset();
            wr(3'd2, 16'(VEC[k][0])); wr(3'd3, 16'(VEC[k][1]));
            wr(3'd5, 16'(VEC[k][2])); wr(3'd6, 16'(VEC[k][3]));
            @(negedge clk); tick = 1'b1;
            wr(3'd0, 16'd1);
            repeat (VEC[k][1] + 4) @(negedge clk);
            ha = 0; hb = 0; zc = 0;
            reg_addr = 3'd7;
            for (int c = 0; c < 2 * (VEC[k][1] + 1); c++) begin
                #0.5;
                if (pwm_a) ha++;
                if (pwm_b) hb++;
                if (reg_rdata == 16'd0) zc++;
                @(negedge clk);
            end
            tick = 1'b0;
            chk(ha == 2 * VEC[k][4], "R4/R6 A high ticks", ha, 2 * VEC[k][4]);
            chk(hb == 2 * VEC[k][5], "R5/R6 B high ticks", hb, 2 * VEC[k][5]);
            chk(zc == 2, "R3 period wraps", zc, 2);
        end

        // R2 tick gating
        do_reset();
        wr(3'd3, 16'd200); wr(3'd0, 16'd1);
        repeat (6) @(negedge clk);
        rd(3'd7, v); chk(v == 0, "R2 no tick no count", v, 0);
        ticks(3);
        rd(3'd7, v); chk(v == 3, "R2 three ticks", v, 3);

        // R7 freeze and resume
        do_reset();
        wr(3'd2, 16'd2); wr(3'd3, 16'd9); wr(3'd5, 16'd1); wr(3'd6, 16'd8);
        @(negedge clk); tick = 1'b1;
        wr(3'd0, 16'd1);
        for (int i = 0; i < 30 && !pwm_a; i++) @(negedge clk);
        wr(3'd0, 16'd0);
        repeat (3) @(negedge clk);
        rd(3'd7, c0); pa0 = int'(pwm_a);
        repeat (10) @(negedge clk);
        rd(3'd7, v);
        chk(v == c0, "R7 count frozen", v, c0);
        chk(int'(pwm_a) == pa0 && pa0 == 1, "R7 output A frozen high", int'(pwm_a), 1);
        chk(pwm_b == 1, "R7 output B frozen high", int'(pwm_b), 1);
        wr(3'd0, 16'd1);
        repeat (3) @(negedge clk);
        rd(3'd7, v);
        chk(v != c0, "R7 resumes", v, c0 + 1);
        tick = 1'b0;

        // R8 R9 flags
        do_reset();
        wr(3'd3, 16'd6); wr(3'd6, 16'd100); wr(3'd0, 16'd1);
        @(negedge clk);
        ticks(6);
        rd(3'd1, v); chk(v == 0, "R8 flags clear before match", v, 0);
        @(negedge clk);
        tick = 1'b1; reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 16'd0;
        @(negedge clk);
        tick = 1'b0; reg_we = 1'b0;
        rd(3'd1, v); chk(v == 1, "R9 match beats clear", v, 1);
        rd(3'd7, v); chk(v == 0, "R3 wrap after match", v, 0);
        wr(3'd1, 16'd3);
        rd(3'd1, v); chk(v == 1, "R8 write one ignored", v, 1);
        wr(3'd1, 16'd0);
        rd(3'd1, v); chk(v == 0, "R8 write zero clears", v, 0);
        wr(3'd6, 16'd2);
        ticks(3);
        rd(3'd1, v); chk(v == 2, "R8 flag B on fall match", v, 2);

        // R10 buffered period
        do_reset();
        wr(3'd0, 16'd2); wr(3'd3, 16'd9); wr(3'd4, 16'd9); wr(3'd0, 16'd3);
        @(negedge clk);
        ticks(3);
        wr(3'd4, 16'd4);
        rd(3'd3, v); chk(v == 9, "R10 no early reload", v, 9);
        ticks(6);
        rd(3'd7, v); chk(v == 9, "R10 old period kept", v, 9);
        ticks(1);
        rd(3'd7, v); chk(v == 0, "R10 wrap at old period", v, 0);
        rd(3'd3, v); chk(v == 4, "R10 reload at wrap", v, 4);
        ticks(4);
        rd(3'd7, v); chk(v == 4, "R10 new period count", v, 4);
        ticks(1);
        rd(3'd7, v); chk(v == 0, "R10 wrap at new period", v, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule